// File: doc/BRIEF.md
# PHY Power-Up Reset Sequencer

This block takes a two-port USB2 PHY out of reset and puts it back into reset, one step at a time, in a fixed order with timed gaps. Software, or a control block above it, pulses a per-port init or exit request. On init, the sequencer turns on the PHY reference clock and waits. It then releases the shared power-on reset and waits again. Next it asks a separate register-write engine to set the PHY clock-enable bit and waits once more. Last, it releases the requesting port's UTMI reset and waits before it raises that port's ready flag. On exit it reverses the order. The UTMI reset goes back on first. The shared power-on reset and the reference clock follow only when no other port is still in use.

Every wait is a cycle count. It equals the wait length in microseconds times a parameter that gives clock cycles per microsecond. A second port that starts while the shared steps are already done skips to its own UTMI release. Requests that arrive during a sequence are remembered and served in port order once the sequencer is idle.

Top module: `phy_rst_seq`

## Requirements
- R1: While reset is asserted and after it is released with no request: `refclk_en`=0, `por_rst`=1, every `utmi_rst` bit =1, `wr_req`=0, `port_ready`=0, `busy`=0.
- R2: An init while no port is ready first raises `refclk_en`. `por_rst` falls exactly REF_WAIT_US*CYC_PER_US cycles after the cycle in which `refclk_en` rose.
- R3: `wr_req` rises exactly POR_WAIT_US*CYC_PER_US cycles after `por_rst` falls. While it is high it carries `wr_port`=0, `wr_addr`=0x06 and `wr_data`=0x04 (bit 2, PHY clock enable). It stays high until `wr_done` is sampled high, and falls in the following cycle.
- R4: The requesting port's `utmi_rst` bit falls exactly CLKEN_WAIT_US*CYC_PER_US cycles after the clock edge at which `wr_done` was accepted.
- R5: A port's `port_ready` bit rises exactly UTMI_WAIT_US*CYC_PER_US cycles after its `utmi_rst` bit falls.
- R6: An init for a port while another port is ready only releases that port's `utmi_rst` and runs its UTMI wait. `refclk_en`, `por_rst` and `wr_req` do not change.
- R7: An exit for the last ready port raises its `utmi_rst` and clears its `port_ready`. `por_rst` rises in the next cycle, and `refclk_en` falls in the cycle after that.
- R8: An exit while another port stays ready raises only that port's `utmi_rst` and clears its `port_ready`. `por_rst` stays 0 and `refclk_en` stays 1.
- R9: Requests that arrive during a sequence are held and served afterwards, lowest port first. Within a port, a pending exit is served before a pending init. A held request starts one cycle after the sequencer becomes idle.
- R10: An init for a port that is already ready, or an exit for a port that is not ready, changes no output other than a brief `busy`.
- R11: `busy` is high from the cycle after a request is sampled until the last pending request has been served.
- R12: `por_rst` is never low while `refclk_en` is low. A `utmi_rst` bit is never low while `por_rst` is high. `port_ready` implies that port's `utmi_rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| init_req | input | NUM_PORTS | Per-port one-cycle init request |
| exit_req | input | NUM_PORTS | Per-port one-cycle exit request |
| wr_done | input | 1 | Register-write engine completion strobe |
| refclk_en | output | 1 | PHY reference clock enable |
| por_rst | output | 1 | Shared power-on reset, active high |
| utmi_rst | output | NUM_PORTS | Per-port UTMI reset, active high |
| wr_req | output | 1 | Request to the register-write engine |
| wr_port | output | 3 | Target PHY port of the write |
| wr_addr | output | 8 | PHY register address of the write |
| wr_data | output | 8 | Data of the write |
| port_ready | output | NUM_PORTS | Port brought fully out of reset |
| busy | output | 1 | Sequence running or request pending |

## Verification
A request strobe can land in the same cycle as another part of the sequencer: a wait expiring, a write completing, or the sequencer making its idle grant. The request logic must latch the new request at the same time as it clears the one being granted. The bench provokes these collisions in three ways. It sends init and exit for one port in the same cycle, it sends both ports' inits together, and it fires random second requests at random offsets into a running sequence. After each burst has drained, it compares the reset outputs with a model that applies every request in port order. It also times each transition against the stated wait lengths.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REF_WAIT,
    S_POR_WAIT,
    S_WR_REQ,
    S_CLK_WAIT,
    S_UTMI_WAIT,
    S_EXIT_POR,
    S_EXIT_REF
  } seq_state_e;

  function automatic int unsigned us_to_cycles(int unsigned us, int unsigned cyc_per_us);
    return us * cyc_per_us;
  endfunction

  function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;
  logic             run;

  // A wait of len cycles: expired is seen in the cycle before edge start+len.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= len - CNT_W'(1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - CNT_W'(1);
    end
  end

  assign expired = run && (cnt == '0);
endmodule

// File: rtl/seq_req_arb.sv
module seq_req_arb #(
  parameter int NP     = 2,
  parameter int PIDX_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NP-1:0]     init_req,
  input  logic [NP-1:0]     exit_req,
  input  logic              take,
  output logic              grant_valid,
  output logic [PIDX_W-1:0] grant_port,
  output logic              grant_exit,
  output logic              any_pend
);
  logic [NP-1:0] pend_init, pend_exit;
  logic [NP-1:0] nxt_init, nxt_exit;

  // Lowest port wins; within a port, exit wins over init.
  always_comb begin
    grant_valid = 1'b0;
    grant_port  = '0;
    grant_exit  = 1'b0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (pend_init[i] || pend_exit[i]) begin
        grant_valid = 1'b1;
        grant_port  = PIDX_W'(i);
        grant_exit  = pend_exit[i];
      end
    end
  end

  // A new strobe in the same cycle as a grant stays pending.
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      nxt_init[i] = init_req[i] | (pend_init[i] &
                    ~(take && grant_valid && !grant_exit && grant_port == PIDX_W'(i)));
      nxt_exit[i] = exit_req[i] | (pend_exit[i] &
                    ~(take && grant_valid && grant_exit && grant_port == PIDX_W'(i)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_init <= '0;
      pend_exit <= '0;
    end else begin
      pend_init <= nxt_init;
      pend_exit <= nxt_exit;
    end
  end

  assign any_pend = (|pend_init) | (|pend_exit);
endmodule

// File: rtl/phy_rst_seq.sv
module phy_rst_seq
  import phy_seq_pkg::*;
#(
  parameter int NUM_PORTS     = 2,
  parameter int CYC_PER_US    = 250,
  parameter int REF_WAIT_US   = 100,
  parameter int POR_WAIT_US   = 300,
  parameter int CLKEN_WAIT_US = 2000,
  parameter int UTMI_WAIT_US  = 2000,
  parameter int WPORT_W       = 3,
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 8,
  parameter logic [WPORT_W-1:0] CLKEN_PORT = '0,
  parameter logic [ADDR_W-1:0]  CLKEN_ADDR = 8'h06,
  parameter logic [DATA_W-1:0]  CLKEN_DATA = 8'h04
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] init_req,
  input  logic [NUM_PORTS-1:0] exit_req,
  input  logic                 wr_done,
  output logic                 refclk_en,
  output logic                 por_rst,
  output logic [NUM_PORTS-1:0] utmi_rst,
  output logic                 wr_req,
  output logic [WPORT_W-1:0]   wr_port,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [DATA_W-1:0]    wr_data,
  output logic [NUM_PORTS-1:0] port_ready,
  output logic                 busy
);
  localparam int unsigned REF_CYC  = us_to_cycles(REF_WAIT_US, CYC_PER_US);
  localparam int unsigned POR_CYC  = us_to_cycles(POR_WAIT_US, CYC_PER_US);
  localparam int unsigned CLK_CYC  = us_to_cycles(CLKEN_WAIT_US, CYC_PER_US);
  localparam int unsigned UTMI_CYC = us_to_cycles(UTMI_WAIT_US, CYC_PER_US);
  localparam int unsigned LONGEST  = max_of4(REF_CYC, POR_CYC, CLK_CYC, UTMI_CYC);
  localparam int CNT_W  = $clog2(LONGEST + 1);
  localparam int PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam logic [CNT_W-1:0] REF_LEN  = CNT_W'(REF_CYC);
  localparam logic [CNT_W-1:0] POR_LEN  = CNT_W'(POR_CYC);
  localparam logic [CNT_W-1:0] CLK_LEN  = CNT_W'(CLK_CYC);
  localparam logic [CNT_W-1:0] UTMI_LEN = CNT_W'(UTMI_CYC);

  seq_state_e state;
  logic [PIDX_W-1:0] cur_port;
  logic shared_up;

  // Named events shared with the checker.
  logic              grant_valid, grant_exit, any_pend, take;
  logic [PIDX_W-1:0] grant_port;
  logic              ev_init_grant, ev_exit_grant, ev_wr_accept, tmr_expired;
  logic              tmr_start, others_ready;
  logic [CNT_W-1:0]  tmr_len;
  logic [NUM_PORTS-1:0] grant_mask;

  seq_req_arb #(.NP(NUM_PORTS), .PIDX_W(PIDX_W)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_req    (init_req),
    .exit_req    (exit_req),
    .take        (take),
    .grant_valid (grant_valid),
    .grant_port  (grant_port),
    .grant_exit  (grant_exit),
    .any_pend    (any_pend)
  );

  seq_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .len     (tmr_len),
    .expired (tmr_expired)
  );

  always_comb begin
    grant_mask = '0;
    grant_mask[grant_port] = 1'b1;
  end

  assign take          = (state == S_IDLE) && grant_valid;
  assign ev_init_grant = take && !grant_exit && !port_ready[grant_port];
  assign ev_exit_grant = take && grant_exit && port_ready[grant_port];
  assign ev_wr_accept  = (state == S_WR_REQ) && wr_done;
  assign others_ready  = |(port_ready & ~grant_mask);

  always_comb begin
    tmr_start = 1'b0;
    tmr_len   = UTMI_LEN;
    if (ev_init_grant) begin
      tmr_start = 1'b1;
      tmr_len   = shared_up ? UTMI_LEN : REF_LEN;
    end else if (state == S_REF_WAIT && tmr_expired) begin
      tmr_start = 1'b1;
      tmr_len   = POR_LEN;
    end else if (ev_wr_accept) begin
      tmr_start = 1'b1;
      tmr_len   = CLK_LEN;
    end else if (state == S_CLK_WAIT && tmr_expired) begin
      tmr_start = 1'b1;
      tmr_len   = UTMI_LEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cur_port   <= '0;
      shared_up  <= 1'b0;
      refclk_en  <= 1'b0;
      por_rst    <= 1'b1;
      utmi_rst   <= '1;
      port_ready <= '0;
      wr_req     <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (ev_init_grant) begin
            cur_port <= grant_port;
            if (shared_up) begin
              utmi_rst[grant_port] <= 1'b0;
              state <= S_UTMI_WAIT;
            end else begin
              refclk_en <= 1'b1;
              state <= S_REF_WAIT;
            end
          end else if (ev_exit_grant) begin
            utmi_rst[grant_port]   <= 1'b1;
            port_ready[grant_port] <= 1'b0;
            if (!others_ready) state <= S_EXIT_POR;
          end
        end
        S_REF_WAIT: if (tmr_expired) begin
          por_rst <= 1'b0;
          state   <= S_POR_WAIT;
        end
        S_POR_WAIT: if (tmr_expired) begin
          wr_req <= 1'b1;
          state  <= S_WR_REQ;
        end
        S_WR_REQ: if (wr_done) begin
          wr_req <= 1'b0;
          state  <= S_CLK_WAIT;
        end
        S_CLK_WAIT: if (tmr_expired) begin
          shared_up          <= 1'b1;
          utmi_rst[cur_port] <= 1'b0;
          state              <= S_UTMI_WAIT;
        end
        S_UTMI_WAIT: if (tmr_expired) begin
          port_ready[cur_port] <= 1'b1;
          state                <= S_IDLE;
        end
        S_EXIT_POR: begin
          por_rst   <= 1'b1;
          shared_up <= 1'b0;
          state     <= S_EXIT_REF;
        end
        S_EXIT_REF: begin
          refclk_en <= 1'b0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign wr_port = CLKEN_PORT;
  assign wr_addr = CLKEN_ADDR;
  assign wr_data = CLKEN_DATA;
  assign busy    = (state != S_IDLE) || any_pend;
endmodule

// File: rtl/phy_rst_seq_chk.sv
module phy_rst_seq_chk #(
  parameter int NUM_PORTS = 2,
  parameter int WPORT_W   = 3,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_done,
  input logic                 refclk_en,
  input logic                 por_rst,
  input logic [NUM_PORTS-1:0] utmi_rst,
  input logic                 wr_req,
  input logic [WPORT_W-1:0]   wr_port,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [DATA_W-1:0]    wr_data,
  input logic [NUM_PORTS-1:0] port_ready,
  input logic                 ev_wr_accept
);
  AST_POR_NEEDS_REFCLK: assert property (@(posedge clk) disable iff (!rst_n)
    !por_rst |-> refclk_en); // R12

  AST_REFCLK_OFF_AFTER_POR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(refclk_en) |-> $past(por_rst)); // R7

  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_done |=> wr_req); // R3

  AST_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_accept |=> !wr_req); // R3

  AST_WR_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_port == '0 && wr_addr == ADDR_W'(8'h06) && wr_data == DATA_W'(8'h04))); // R3

  AST_WR_IN_SHARED_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (!por_rst && refclk_en && (&utmi_rst))); // R12

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    AST_UTMI_NEEDS_POR: assert property (@(posedge clk) disable iff (!rst_n)
      !utmi_rst[p] |-> !por_rst); // R12
    AST_READY_UTMI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      port_ready[p] |-> !utmi_rst[p]); // R12
  end
endmodule

bind phy_rst_seq phy_rst_seq_chk #(
  .NUM_PORTS (NUM_PORTS),
  .WPORT_W   (WPORT_W),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_done      (wr_done),
  .refclk_en    (refclk_en),
  .por_rst      (por_rst),
  .utmi_rst     (utmi_rst),
  .wr_req       (wr_req),
  .wr_port      (wr_port),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .port_ready   (port_ready),
  .ev_wr_accept (ev_wr_accept)
);

// File: tb/phy_rst_seq_bench.sv
`timescale 1ns/1ps
module phy_rst_seq_bench;
  localparam int NP = 2, CPU = 2;
  localparam int REF_US = 5, POR_US = 7, CLK_US = 4, UTMI_US = 6;

  logic clk = 1'b0, rst_n = 1'b0, wr_done = 1'b0;
  logic [NP-1:0] init_req = '0, exit_req = '0;
  logic refclk_en, por_rst, wr_req, busy;
  logic [NP-1:0] utmi_rst, port_ready;
  logic [2:0] wr_port;
  logic [7:0] wr_addr, wr_data;

  phy_rst_seq #(.NUM_PORTS(NP), .CYC_PER_US(CPU), .REF_WAIT_US(REF_US),
    .POR_WAIT_US(POR_US), .CLKEN_WAIT_US(CLK_US), .UTMI_WAIT_US(UTMI_US)) u_phy_rst_seq (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .exit_req(exit_req), .wr_done(wr_done),
    .refclk_en(refclk_en), .por_rst(por_rst), .utmi_rst(utmi_rst), .wr_req(wr_req),
    .wr_port(wr_port), .wr_addr(wr_addr), .wr_data(wr_data), .port_ready(port_ready), .busy(busy));

  always #2 clk = ~clk;

  function automatic int wait_cycles(int us);
    int c = 0;
    for (int i = 0; i < us; i++) c += CPU;
    return c;
  endfunction

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Event timestamps kept by the monitor
  int t_ref, t_por, t_wd, t_pr, n_ref_rise = 0, n_wr_rise = 0;
  int t_uf[NP], t_ur[NP], t_rdy[NP];
  bit wd_full = 0;

  initial begin : monitor
    logic p_ref, p_por, p_wr;
    logic [NP-1:0] p_utmi, p_rdy;
    p_ref = 0; p_por = 1; p_wr = 0; p_utmi = '1; p_rdy = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (refclk_en && !p_ref) begin t_ref = cyc; n_ref_rise++; end
        if (!por_rst && p_por) begin
          check(cyc - t_ref == wait_cycles(REF_US), "R2", cyc - t_ref, wait_cycles(REF_US));
          t_por = cyc;
        end
        if (wr_req && !p_wr) begin
          n_wr_rise++;
          check(cyc - t_por == wait_cycles(POR_US), "R3", cyc - t_por, wait_cycles(POR_US));
          check(wr_port == 0 && wr_addr == 8'h06 && wr_data == 8'h04, "R3",
                int'({wr_port, wr_addr, wr_data}), int'({3'd0, 8'h06, 8'h04}));
        end
        for (int p = 0; p < NP; p++) begin
          if (!utmi_rst[p] && p_utmi[p]) begin
            t_uf[p] = cyc;
            if (wd_full) begin
              check(cyc - t_wd == wait_cycles(CLK_US), "R4", cyc - t_wd, wait_cycles(CLK_US));
              wd_full = 0;
            end
          end
          if (utmi_rst[p] && !p_utmi[p]) t_ur[p] = cyc;
          if (port_ready[p] && !p_rdy[p]) begin
            t_rdy[p] = cyc;
            check(cyc - t_uf[p] == wait_cycles(UTMI_US), "R5", cyc - t_uf[p], wait_cycles(UTMI_US));
          end
        end
        if (por_rst && !p_por) begin
          t_pr = cyc;
          check(cyc - t_ur[0] == 1 || cyc - t_ur[1] == 1, "R7", cyc, t_ur[0] + 1);
        end
        if (!refclk_en && p_ref) check(cyc - t_pr == 1, "R7", cyc - t_pr, 1);
      end
      p_ref = refclk_en; p_por = por_rst; p_wr = wr_req; p_utmi = utmi_rst; p_rdy = port_ready;
    end
  end

  // Register-write engine model with random latency
  initial begin : engine
    forever begin
      @(negedge clk);
      if (wr_req) begin
        repeat ($urandom_range(0, 3)) @(negedge clk);
        wr_done = 1; t_wd = cyc + 1; wd_full = 1;
        @(negedge clk);
        wr_done = 0;
      end
    end
  end

  logic [NP-1:0] model = '0;

  task automatic pulse(logic [NP-1:0] ini, logic [NP-1:0] ext);
    @(negedge clk);
    init_req = ini; exit_req = ext;
    @(negedge clk);
    init_req = '0; exit_req = '0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic check_state(string req);
    check(port_ready == model, req, int'(port_ready), int'(model));
    check(utmi_rst == ~model, req, int'(utmi_rst), int'(~model));
    check(por_rst == !(|model) && refclk_en == (|model), req,
          int'({por_rst, refclk_en}), int'({!(|model), |model}));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stimulus
    int rr, rs;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!refclk_en && por_rst && utmi_rst == '1 && !wr_req && port_ready == 0 && !busy,
          "R1", int'({refclk_en, por_rst, utmi_rst, wr_req, port_ready, busy}), int'(8'b0_1_11_0_00_0));
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!refclk_en && por_rst && utmi_rst == '1 && !busy, "R1",
          int'({refclk_en, por_rst, utmi_rst, busy}), int'(5'b0_1_11_0));

    // Full bring-up of port 0
    pulse(2'b01, 2'b00);
    check(busy, "R11", busy, 1);
    wait_idle(); model = 2'b01; check_state("R2");

    // Second port with shared domain up
    rr = n_ref_rise; rs = n_wr_rise;
    pulse(2'b10, 2'b00); wait_idle(); model = 2'b11;
    check(n_ref_rise == rr && n_wr_rise == rs, "R6", n_wr_rise, rs);
    check_state("R6");

    // Ignored requests
    pulse(2'b01, 2'b00); wait_idle(); check_state("R10");
    check(t_uf[0] < t_rdy[0], "R10", t_uf[0], t_rdy[0]);

    // Exit with another port still up
    pulse(2'b00, 2'b01); wait_idle(); model = 2'b10; check_state("R8");
    pulse(2'b00, 2'b01); wait_idle(); check_state("R10");

    // Last port down: full teardown ordering
    pulse(2'b00, 2'b10); wait_idle(); model = 2'b00; check_state("R7");

    // Both inits in one cycle: port 0 first, port 1 one cycle after
    pulse(2'b11, 2'b00); wait_idle(); model = 2'b11; check_state("R9");
    check(t_uf[1] == t_rdy[0] + 1, "R9", t_uf[1], t_rdy[0] + 1);

    // Exit and init of port 0 in one cycle: exit first
    pulse(2'b01, 2'b01); wait_idle(); check_state("R9");
    check(t_uf[0] == t_ur[0] + 1, "R9", t_uf[0], t_ur[0] + 1);

    // Request held during a running sequence
    pulse(2'b00, 2'b11); wait_idle(); model = 2'b00; check_state("R7");
    pulse(2'b01, 2'b00);
    repeat (10) @(negedge clk);
    pulse(2'b10, 2'b00); wait_idle(); model = 2'b11; check_state("R9");
    check(t_uf[1] == t_rdy[0] + 1, "R9", t_uf[1], t_rdy[0] + 1);

    // Random bursts
    for (int it = 0; it < 30; it++) begin
      int p = $urandom_range(0, 1);
      bit ex = $urandom_range(0, 1);
      pulse(ex ? 2'b00 : NP'(1 << p), ex ? NP'(1 << p) : 2'b00);
      model[p] = !ex;
      if ($urandom_range(0, 1)) begin
        int q = 1 - p;
        bit ex2 = $urandom_range(0, 1);
        repeat ($urandom_range(0, 40)) @(negedge clk);
        pulse(ex2 ? 2'b00 : NP'(1 << q), ex2 ? NP'(1 << q) : 2'b00);
        model[q] = !ex2;
      end
      wait_idle();
      check_state("R9");
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule